// File: doc/BRIEF.md
# Segmented Long-Period PWM Generator

This block drives a pulse-width-modulated pin whose active time and inactive time are each set as a 16-bit count of clock ticks. The only timing element inside it is an 8-bit auto-reload counter. Each phase is therefore built as a chain of counter segments. Every full segment lasts 255 ticks, and one shorter segment finishes the phase.

A segment that is too short would leave too little time for the next reload. Such a segment is never emitted. When the final piece of a phase would fall below a minimum-segment threshold, that piece and the full segment before it are merged. The merged stretch is then emitted as two nearly equal halves, so the phase length stays exact. A phase that is shorter than the threshold as a whole is stretched to the threshold.

The active and inactive counts and the threshold are sampled only when a new period begins, so an update never cuts a period short. A polarity input picks which pin level counts as active. A one-cycle marker pulse shows the first tick of every segment.

Top module: `pwmseg_gen`

## Requirements
- R1: After reset, and whenever `en_i` is low, `pwm_o` equals `pol_i` (the inactive level) and `seg_mark_o` is 0.
- R2: After `en_i` is sampled high at a clock edge, `pwm_o` holds the active level (`!pol_i`) for exactly H' cycles, starting in the cycle after that edge. It then holds the inactive level for exactly L' cycles, and the pattern repeats. H' and L' are the effective high and low lengths defined in R3 and R6.
- R3: A phase of length P is split into segments. While the remaining length exceeds 510, a 255-tick segment is emitted. A remaining length of 255 or less is emitted as one final segment. Example: 1000 gives 255,255,255,235, and 400 gives 255,145.
- R4: When a phase is an exact multiple of 255, no extra segment follows the full ones. Example: 765 gives three 255-tick segments.
- R5: When the remaining length R is between 256 and 510 and R−255 is below the threshold, two segments of ceil(R/2) and floor(R/2) are emitted instead. Examples: 300 with a threshold of 55 gives 150,150, and 1285 with a threshold of 110 gives 255,255,255,255,133,132.
- R6: A phase count below the threshold, zero included, becomes a single segment whose length equals the threshold.
- R7: `hi_len_i`, `lo_len_i` and `min_seg_i` are sampled only at the start of an active phase that begins a period. A change made mid-period takes effect in the next period.
- R8: `pol_i` inverts `pwm_o` combinationally, in the same cycle it changes.
- R9: `seg_mark_o` is 1 during the first cycle of every segment and 0 in every other cycle.
- R10: When `en_i` is sampled low at a clock edge, `pwm_o` returns to `pol_i` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one tick per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| pol_i | input | 1 | Inactive pin level; the active level is its inverse |
| hi_len_i | input | 16 | Active phase length in ticks |
| lo_len_i | input | 16 | Inactive phase length in ticks |
| min_seg_i | input | 8 | Minimum segment length in ticks (1..128) |
| pwm_o | output | 1 | PWM pin |
| seg_mark_o | output | 1 | First-tick marker of each segment |

## Verification
The assertions assume that `min_seg_i` lies between 1 and 128. This keeps the two merged halves, each at least 128 ticks, and every clamped segment at or above the threshold and never zero. The stimulus uses only threshold values of 40, 55 and 110. It changes the counts only while the block is disabled, or mid-period where R7 defines the outcome. Every directed case records the pin and the marker over a whole period plus one cycle, so the start of the following period is also checked.

// File: rtl/pwmseg_pkg.sv
package pwmseg_pkg;

    parameter int unsigned SEG_W = 8;
    parameter int unsigned LEN_W = 16;

    localparam int unsigned SEG_FULL = (1 << SEG_W) - 1;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } phase_e;

    typedef struct packed {
        seg_t seg_len;
        len_t rest;
    } plan_t;

    // Phase length stretched up to the threshold when shorter.
    function automatic len_t clamp_len(len_t l, seg_t m);
        return (l < len_t'(m)) ? len_t'(m) : l;
    endfunction

    // Start value so that the counter reaches all ones after len ticks.
    function automatic seg_t reload_of(seg_t len);
        return seg_t'(0) - len;
    endfunction

endpackage

// File: rtl/pwmseg_split.sv
module pwmseg_split
    import pwmseg_pkg::*;
(
    input  len_t  rem_i,
    input  seg_t  min_i,
    output plan_t plan_o
);
    localparam len_t FULL     = len_t'(SEG_FULL);
    localparam len_t TWO_FULL = len_t'(2 * SEG_FULL);

    len_t tail;
    len_t half_up;
    seg_t seg;

    always_comb begin
        tail    = rem_i - FULL;
        half_up = (rem_i + len_t'(1)) >> 1;
        if (rem_i > TWO_FULL) begin
            seg = seg_t'(SEG_FULL);
        end else if (rem_i > FULL) begin
            seg = (tail >= len_t'(min_i)) ? seg_t'(SEG_FULL) : half_up[SEG_W-1:0];
        end else begin
            seg = rem_i[SEG_W-1:0];
        end
        plan_o.seg_len = seg;
        plan_o.rest    = rem_i - len_t'(seg);
    end

    // R5
    always_comb begin
        if (rem_i > FULL && rem_i <= TWO_FULL && seg != seg_t'(SEG_FULL)) begin
            halves_even_chk: assert (plan_o.rest <= len_t'(seg) &&
                                     (len_t'(seg) - plan_o.rest) <= len_t'(1));
        end
    end

endmodule

// File: rtl/pwmseg_arcnt.sv
module pwmseg_arcnt
    import pwmseg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic load_i,
    input  seg_t reload_i,
    output logic wrap_o
);
    seg_t cnt;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= reload_i;
        end else if (run_i) begin
            cnt <= cnt + seg_t'(1);
        end
    end

    assign wrap_o = run_i && (cnt == '1);

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i && $past(run_i) && !$past(load_i) |-> cnt == $past(cnt) + seg_t'(1));

endmodule

// File: rtl/pwmseg_seq.sv
module pwmseg_seq
    import pwmseg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  len_t hi_len_i,
    input  len_t lo_len_i,
    input  seg_t min_seg_i,
    output logic level_on_o,
    output logic mark_o
);
    logic   active;
    phase_e phase;
    len_t   rem;
    len_t   lo_lat;
    seg_t   min_lat;
    logic   mark_q;

    logic   start, fin, relatch, load, wrap;
    len_t   src;
    seg_t   min_use;
    phase_e nxt_ph;
    plan_t  plan;

    always_comb begin
        start   = !active && en_i;
        fin     = wrap && (rem == '0);
        relatch = start || (fin && phase == PH_OFF);
        if (relatch) begin
            src     = clamp_len(hi_len_i, min_seg_i);
            min_use = min_seg_i;
            nxt_ph  = PH_ON;
        end else if (fin) begin
            src     = clamp_len(lo_lat, min_lat);
            min_use = min_lat;
            nxt_ph  = PH_OFF;
        end else begin
            src     = rem;
            min_use = min_lat;
            nxt_ph  = phase;
        end
        load = en_i && (start || wrap);
    end

    pwmseg_split u_split (
        .rem_i  (src),
        .min_i  (min_use),
        .plan_o (plan)
    );

    pwmseg_arcnt u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (active),
        .load_i   (load),
        .reload_i (reload_of(plan.seg_len)),
        .wrap_o   (wrap)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active  <= 1'b0;
            phase   <= PH_ON;
            rem     <= '0;
            lo_lat  <= '0;
            min_lat <= seg_t'(1);
            mark_q  <= 1'b0;
        end else begin
            mark_q <= load;
            if (!en_i) begin
                active <= 1'b0;
            end else if (load) begin
                active <= 1'b1;
                phase  <= nxt_ph;
                rem    <= plan.rest;
                if (relatch) begin
                    lo_lat  <= lo_len_i;
                    min_lat <= min_seg_i;
                end
            end
        end
    end

    assign level_on_o = active && (phase == PH_ON);
    assign mark_o     = mark_q;

    // R6
    seg_min_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load |-> (plan.seg_len >= min_use) && (plan.seg_len != '0));

    // R2
    phase_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        active && $past(active) && !$past(wrap) |-> $stable(phase));

    // R7
    latch_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(active) && !$past(load && relatch) |-> $stable(lo_lat) && $stable(min_lat));

    // R9
    mark_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mark_o && active |=> !mark_o || $past(wrap));

endmodule

// File: rtl/pwmseg_gen.sv
module pwmseg_gen
    import pwmseg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic [LEN_W-1:0] hi_len_i,
    input  logic [LEN_W-1:0] lo_len_i,
    input  logic [SEG_W-1:0] min_seg_i,
    output logic             pwm_o,
    output logic             seg_mark_o
);
    logic level_on;

    pwmseg_seq u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .hi_len_i   (hi_len_i),
        .lo_len_i   (lo_len_i),
        .min_seg_i  (min_seg_i),
        .level_on_o (level_on),
        .mark_o     (seg_mark_o)
    );

    assign pwm_o = level_on ^ pol_i;

    // R10
    off_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(en_i) |-> !level_on && !seg_mark_o);

endmodule

// File: tb/pwmseg_gen_test.sv
`timescale 1ns/1ps
module pwmseg_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        pol = 1'b0;
    logic [15:0] hi  = 16'd0;
    logic [15:0] lo  = 16'd0;
    logic [7:0]  mn  = 8'd55;
    logic        pwm, mark;

    int checks = 0;
    int fails  = 0;

    bit pin_s  [4096];
    bit mark_s [4096];
    int nrec = 0;
    int exp_q [$];
    bit lvl_q [$];

    always #2.5 clk = ~clk;

    pwmseg_gen uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .en_i       (en),
        .pol_i      (pol),
        .hi_len_i   (hi),
        .lo_len_i   (lo),
        .min_seg_i  (mn),
        .pwm_o      (pwm),
        .seg_mark_o (mark)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic record(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pin_s[nrec]  = pwm;
            mark_s[nrec] = mark;
            nrec++;
        end
    endtask

    task automatic push(int len, bit lvl);
        exp_q.push_back(len);
        lvl_q.push_back(lvl);
    endtask

    task automatic begin_run(int h, int l, int m, bit p);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        hi = 16'(h); lo = 16'(l); mn = 8'(m); pol = p;
        en = 1'b1;
        nrec = 0;
        exp_q.delete();
        lvl_q.delete();
    endtask

    // Walk the expected segment list over the recorded samples (R9 marker + level)
    task automatic verify(string req);
        int pos = 0;
        for (int k = 0; k < exp_q.size(); k++) begin
            int  len  = exp_q[k];
            bit  ok   = (mark_s[pos] == 1'b1);
            int  meas = len;
            for (int j = pos; j < pos + len; j++) begin
                if (pin_s[j] != (lvl_q[k] ^ pol)) ok = 1'b0;
                if (j > pos && mark_s[j]) begin
                    ok = 1'b0;
                    if (meas == len) meas = j - pos;
                end
            end
            check(ok, req, $sformatf("segment %0d length", k), meas, len);
            pos += len;
        end
        check(mark_s[pos] == 1'b1 && pin_s[pos] == ~pol, req, "next period start", mark_s[pos], 1);
    endtask

    task automatic t_reset;
        // R1
        @(negedge clk);
        check(pwm == pol && mark == 1'b0, "R1", "reset pin level", pwm, pol);
        pol = 1'b1;
        #1;
        check(pwm == 1'b1, "R1", "disabled pin follows polarity", pwm, 1);
        pol = 1'b0;
    endtask

    task automatic t_basic;
        int on_cnt = 0;
        int off_cnt = 0;
        int i = 0;
        begin_run(1000, 400, 55, 1'b0);
        record(1401);
        while (i < nrec && pin_s[i] == 1'b1) begin on_cnt++; i++; end
        while (i < nrec && pin_s[i] == 1'b0) begin off_cnt++; i++; end
        check(on_cnt == 1000, "R2", "active cycles", on_cnt, 1000);
        check(off_cnt == 400, "R2", "inactive cycles", off_cnt, 400);
        push(255, 1); push(255, 1); push(255, 1); push(235, 1);
        push(255, 0); push(145, 0);
        verify("R3/R9");
    endtask

    task automatic t_exact_merge;
        // R4 on the active phase, R5 (even) on the inactive phase
        begin_run(765, 300, 55, 1'b0);
        record(1066);
        push(255, 1); push(255, 1); push(255, 1);
        push(150, 0); push(150, 0);
        verify("R4/R5");
    endtask

    task automatic t_odd_clamp;
        // R5 odd halves, R6 clamp of a short inactive phase
        begin_run(1285, 60, 110, 1'b0);
        record(1396);
        push(255, 1); push(255, 1); push(255, 1); push(255, 1);
        push(133, 1); push(132, 1);
        push(110, 0);
        verify("R5/R6");
    endtask

    task automatic t_zero_pol;
        bit p;
        // R6 zero count clamps, R8 inverted polarity
        begin_run(0, 20, 40, 1'b1);
        record(81);
        push(40, 1); push(40, 0);
        verify("R6/R8");
        p = pwm;
        pol = ~pol;
        #1;
        check(pwm == ~p, "R8", "polarity flip same cycle", pwm, ~p);
        pol = ~pol;
    endtask

    task automatic t_update;
        // R7: change counts mid-period; current period unaffected
        begin_run(1000, 400, 55, 1'b0);
        record(10);
        hi = 16'd100;
        record(1400 - 10 + 500 + 1);
        push(255, 1); push(255, 1); push(255, 1); push(235, 1);
        push(255, 0); push(145, 0);
        push(100, 1); push(255, 0); push(145, 0);
        verify("R7");
    endtask

    task automatic t_disable;
        // R10
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(pwm == pol, "R10", "pin after disable", pwm, pol);
        check(mark == 1'b0, "R10", "marker after disable", mark, 0);
        @(negedge clk);
        check(pwm == pol && mark == 1'b0, "R1", "stays idle", pwm, pol);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_exact_merge();
        t_odd_clamp();
        t_zero_pol();
        t_update();
        t_disable();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule